// File: doc/BRIEF.md
# Serial Register Burst Master

This block is the master side of a four-wire serial link to a peripheral's register space. It drives a serial clock, a data-out line and an active-low select, and it samples a data-in line. A host starts a transaction with a single-cycle start pulse. With that pulse it gives a register address, a direction flag and a byte count from 1 to 15. The block then pulls select low and shifts out the address byte. A control byte follows, carrying the direction and the count. After that come the data bytes, all under the one select assertion.

In a write burst the block asks the host for each data byte with a one-cycle request pulse. The request comes one byte ahead of the byte being shifted, so the host has a whole byte time to answer. In a read burst the block holds data-out low and samples data-in on each rising serial clock edge. Each assembled byte is returned with a one-cycle valid strobe. The serial clock runs at the system clock divided by twice the `DIV_HALF` parameter. A done pulse closes each transaction. A start with a zero count is refused with an error pulse.

Top module: `sreg_burst_master`

## Requirements
- R1: While reset is applied and right after it, select is high, serial clock and data-out are low, and busy, done, error, valid and request are all low.
- R2: The first byte shifted out after select falls is the register address, most significant bit first.
- R3: The second byte is the control byte. Bit 7 is the direction (1 = write, 0 = read), bits 6:4 are sent as 0, and bits 3:0 carry the byte count.
- R4: The serial clock idles low while select is high. Data-out never changes while the serial clock stays high; it changes only at a falling edge, so the peripheral can sample it on the rising edge.
- R5: Every serial clock half-period lasts `DIV_HALF` system cycles. Select falls exactly `DIV_HALF` cycles before the first rising edge and rises exactly `DIV_HALF` cycles after the last falling edge.
- R6: A transaction with count N makes exactly 8*(N+2) rising serial clock edges under a single select assertion.
- R7: In a write burst, `wreq_o` pulses once each time the control byte or a non-final data byte is loaded into the shifter, so N times for count N. The byte on `wdata_i` is captured when the next data byte is loaded, and the data bytes appear on data-out in request order.
- R8: In a read burst, data-out stays 0 during the data bytes. Each data byte is returned on `rdata_o` with a one-cycle `rvalid_o` pulse in the cycle its eighth rising edge appears. There are N pulses in all, and no pulses in a write burst.
- R9: A start with count 0 gives a one-cycle `err_o` pulse in the next cycle. Select stays high and no done pulse follows.
- R10: A start pulse while a transaction is busy is ignored. The running transaction finishes unchanged and no second select assertion follows.
- R11: `busy_o` is high from the cycle after an accepted start until select rises. `done_o` is a one-cycle pulse in the first cycle select is high again, and `busy_o` is already low in that cycle.
- R12: The largest count, 15, runs a full 17-byte frame in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle transaction request |
| addr_i | input | 8 | Register address, sampled with start |
| write_i | input | 1 | 1 = write burst, 0 = read burst, sampled with start |
| count_i | input | 4 | Data byte count 1..15, sampled with start |
| wdata_i | input | 8 | Next write data byte, supplied after each request |
| wreq_o | output | 1 | One-cycle request for the next write byte |
| rdata_o | output | 8 | Last received read byte |
| rvalid_o | output | 1 | One-cycle strobe for `rdata_o` |
| done_o | output | 1 | One-cycle pulse when a transaction ends |
| err_o | output | 1 | One-cycle pulse when a zero-count start is refused |
| busy_o | output | 1 | Transaction in progress |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the peripheral |
| miso_i | input | 1 | Serial data from the peripheral |
| csn_o | output | 1 | Active-low select |

## Verification
Select falls and busy rises in the cycle after the start is taken. An error pulse likewise shows up one cycle after a zero-count start. The first rising serial edge comes `DIV_HALF` cycles after select falls, and each later edge comes `DIV_HALF` cycles after the one before. A read byte's valid strobe is due in the same cycle as that byte's eighth rising edge. Done and the release of select are due together, `DIV_HALF` cycles after the last falling edge. The bench samples every output at the falling system clock edge and stamps each serial edge with a cycle counter, so it checks these spacings exactly rather than with a tolerance.

// File: rtl/sbm_pkg.sv
`timescale 1ns/1ps
package sbm_pkg;

  localparam int SBM_BYTE_W = 8;
  localparam int SBM_LEN_W  = 4;
  localparam int SBM_BIT_W  = $clog2(SBM_BYTE_W);
  localparam int SBM_IDX_W  = SBM_LEN_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD
  } sbm_state_e;

  // Control byte: direction on top, three zero bits, burst length below.
  function automatic logic [SBM_BYTE_W-1:0] ctrl_byte(input logic wr,
                                                      input logic [SBM_LEN_W-1:0] len);
    return {wr, 3'b000, len};
  endfunction

  // Index of the final byte in the frame (address and control come first).
  function automatic logic [SBM_IDX_W-1:0] last_idx(input logic [SBM_LEN_W-1:0] len);
    return SBM_IDX_W'(len) + SBM_IDX_W'(1);
  endfunction

  // A request is raised while loading byte idx when byte idx+1 is still data.
  function automatic logic need_wreq(input logic wr,
                                     input logic [SBM_IDX_W-1:0] idx,
                                     input logic [SBM_LEN_W-1:0] len);
    return wr && (idx >= SBM_IDX_W'(1)) && (idx <= SBM_IDX_W'(len));
  endfunction

endpackage

// File: rtl/sbm_halfclk.sv
`timescale 1ns/1ps
module sbm_halfclk #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);

  generate
    if (DIV_HALF <= 1) begin : g_direct
      assign tick_o = run_i;
    end else begin : g_count
      localparam int CW = $clog2(DIV_HALF);
      localparam logic [CW-1:0] TOP = CW'(DIV_HALF - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (!run_i) begin
          cnt_q <= '0;
        end else if (cnt_q == TOP) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end

      assign tick_o = run_i && (cnt_q == TOP);
    end
  endgenerate

endmodule

// File: rtl/sbm_shifter.sv
`timescale 1ns/1ps
module sbm_shifter
  import sbm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [SBM_BYTE_W-1:0] load_val_i,
  input  logic                  shift_i,
  input  logic                  sample_i,
  input  logic                  miso_i,
  output logic                  mosi_o,
  output logic [SBM_BYTE_W-1:0] rx_next_o
);

  logic [SBM_BYTE_W-1:0] tx_q;
  logic [SBM_BYTE_W-2:0] rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
    end else if (load_i) begin
      tx_q <= load_val_i;
    end else if (shift_i) begin
      tx_q <= {tx_q[SBM_BYTE_W-2:0], 1'b0};
    end
  end

  // Only seven bits of history are kept; the eighth is the live input.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (sample_i) begin
      rx_q <= rx_next_o[SBM_BYTE_W-2:0];
    end
  end

  assign rx_next_o = {rx_q, miso_i};
  assign mosi_o    = tx_q[SBM_BYTE_W-1];

endmodule

// File: rtl/sbm_seq.sv
`timescale 1ns/1ps
module sbm_seq
  import sbm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [SBM_BYTE_W-1:0] addr_i,
  input  logic                  write_i,
  input  logic [SBM_LEN_W-1:0]  count_i,
  input  logic [SBM_BYTE_W-1:0] wdata_i,
  input  logic                  tick_i,
  input  logic [SBM_BYTE_W-1:0] rx_next_i,
  output logic                  run_o,
  output logic                  sclk_o,
  output logic                  csn_o,
  output logic                  load_o,
  output logic [SBM_BYTE_W-1:0] load_val_o,
  output logic                  shift_o,
  output logic                  sample_o,
  output logic                  wreq_o,
  output logic [SBM_BYTE_W-1:0] rdata_o,
  output logic                  rvalid_o,
  output logic                  done_o,
  output logic                  err_o,
  output logic                  rise_evt_o,
  output logic                  fall_evt_o
);

  localparam logic [SBM_BIT_W-1:0] BIT_LAST   = SBM_BIT_W'(SBM_BYTE_W - 1);
  localparam logic [SBM_IDX_W-1:0] FIRST_DATA = SBM_IDX_W'(2);

  sbm_state_e             state_q;
  logic                   sclk_q, csn_q, wr_q;
  logic [SBM_LEN_W-1:0]   len_q;
  logic [SBM_BIT_W-1:0]   bit_q;
  logic [SBM_IDX_W-1:0]   idx_q;
  logic                   wreq_q, rvalid_q, done_q, err_q;
  logic [SBM_BYTE_W-1:0]  rdata_q;

  logic accept, reject, bit_end, byte_end, last_byte;
  logic wreq_set, rvalid_set;
  logic [SBM_IDX_W-1:0] next_idx;

  assign accept    = (state_q == ST_IDLE) && start_i && (count_i != '0);
  assign reject    = (state_q == ST_IDLE) && start_i && (count_i == '0);
  assign rise_evt_o = tick_i && ((state_q == ST_SETUP) ||
                                 ((state_q == ST_SHIFT) && !sclk_q));
  assign fall_evt_o = tick_i && (state_q == ST_SHIFT) && sclk_q;
  assign bit_end   = (bit_q == BIT_LAST);
  assign byte_end  = fall_evt_o && bit_end;
  assign last_byte = (idx_q == last_idx(len_q));
  assign next_idx  = idx_q + SBM_IDX_W'(1);

  assign wreq_set   = byte_end && !last_byte && need_wreq(wr_q, next_idx, len_q);
  assign rvalid_set = rise_evt_o && bit_end && (idx_q >= FIRST_DATA) && !wr_q;

  // Shifter control
  assign load_o   = accept || byte_end;
  assign shift_o  = fall_evt_o && !bit_end;
  assign sample_o = rise_evt_o;

  always_comb begin
    if (accept) begin
      load_val_o = addr_i;
    end else if (last_byte) begin
      load_val_o = '0;
    end else if (next_idx == SBM_IDX_W'(1)) begin
      load_val_o = ctrl_byte(wr_q, len_q);
    end else if (wr_q) begin
      load_val_o = wdata_i;
    end else begin
      load_val_o = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sclk_q   <= 1'b0;
      csn_q    <= 1'b1;
      wr_q     <= 1'b0;
      len_q    <= '0;
      bit_q    <= '0;
      idx_q    <= '0;
      wreq_q   <= 1'b0;
      rvalid_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      wreq_q   <= wreq_set;
      rvalid_q <= rvalid_set;
      err_q    <= reject;
      done_q   <= 1'b0;
      if (rvalid_set) rdata_q <= rx_next_i;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_SETUP;
            csn_q   <= 1'b0;
            wr_q    <= write_i;
            len_q   <= count_i;
            bit_q   <= '0;
            idx_q   <= '0;
          end
        end
        ST_SETUP: begin
          if (tick_i) begin
            sclk_q  <= 1'b1;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (rise_evt_o) sclk_q <= 1'b1;
          if (fall_evt_o) begin
            sclk_q <= 1'b0;
            if (bit_end) begin
              bit_q <= '0;
              if (last_byte) state_q <= ST_HOLD;
              else           idx_q   <= next_idx;
            end else begin
              bit_q <= bit_q + SBM_BIT_W'(1);
            end
          end
        end
        ST_HOLD: begin
          if (tick_i) begin
            csn_q   <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o    = (state_q != ST_IDLE);
  assign sclk_o   = sclk_q;
  assign csn_o    = csn_q;
  assign wreq_o   = wreq_q;
  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
  assign done_o   = done_q;
  assign err_o    = err_q;

endmodule

// File: rtl/sreg_burst_master.sv
`timescale 1ns/1ps
module sreg_burst_master
  import sbm_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [SBM_BYTE_W-1:0] addr_i,
  input  logic                  write_i,
  input  logic [SBM_LEN_W-1:0]  count_i,
  input  logic [SBM_BYTE_W-1:0] wdata_i,
  output logic                  wreq_o,
  output logic [SBM_BYTE_W-1:0] rdata_o,
  output logic                  rvalid_o,
  output logic                  done_o,
  output logic                  err_o,
  output logic                  busy_o,
  output logic                  sclk_o,
  output logic                  mosi_o,
  input  logic                  miso_i,
  output logic                  csn_o
);

  // Named internal events, visible to the bound checker
  logic                  half_tick;
  logic                  run;
  logic                  rise_evt;
  logic                  fall_evt;
  logic                  sh_load;
  logic                  sh_shift;
  logic                  sh_sample;
  logic [SBM_BYTE_W-1:0] sh_load_val;
  logic [SBM_BYTE_W-1:0] rx_next;

  sbm_halfclk #(.DIV_HALF(DIV_HALF)) u_halfclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .tick_o (half_tick)
  );

  sbm_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .addr_i     (addr_i),
    .write_i    (write_i),
    .count_i    (count_i),
    .wdata_i    (wdata_i),
    .tick_i     (half_tick),
    .rx_next_i  (rx_next),
    .run_o      (run),
    .sclk_o     (sclk_o),
    .csn_o      (csn_o),
    .load_o     (sh_load),
    .load_val_o (sh_load_val),
    .shift_o    (sh_shift),
    .sample_o   (sh_sample),
    .wreq_o     (wreq_o),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .rise_evt_o (rise_evt),
    .fall_evt_o (fall_evt)
  );

  sbm_shifter u_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (sh_load),
    .load_val_i (sh_load_val),
    .shift_i    (sh_shift),
    .sample_i   (sh_sample),
    .miso_i     (miso_i),
    .mosi_o     (mosi_o),
    .rx_next_o  (rx_next)
  );

  assign busy_o = run;

endmodule

// File: rtl/sbm_checker.sv
`timescale 1ns/1ps
module sbm_checker (
  input logic clk,
  input logic rst_n,
  input logic csn_o,
  input logic sclk_o,
  input logic mosi_o,
  input logic done_o,
  input logic err_o,
  input logic busy_o,
  input logic rvalid_o,
  input logic wreq_o,
  input logic rise_evt,
  input logic fall_evt
);

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    csn_o |-> !sclk_o); // R4

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o)); // R4

  AST_FALL_DROPS_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !sclk_o); // R4

  AST_SELECT_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> $past(!csn_o)); // R5

  AST_RISE_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> !csn_o); // R5

  AST_REFUSE_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (csn_o && !busy_o)); // R9

  AST_DONE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($rose(csn_o) && !busy_o)); // R11

  AST_RVALID_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o |-> $rose(sclk_o)); // R8

  AST_WREQ_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    wreq_o |-> !csn_o); // R7

endmodule

bind sreg_burst_master sbm_checker u_sbm_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .csn_o    (csn_o),
  .sclk_o   (sclk_o),
  .mosi_o   (mosi_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .busy_o   (busy_o),
  .rvalid_o (rvalid_o),
  .wreq_o   (wreq_o),
  .rise_evt (rise_evt),
  .fall_evt (fall_evt)
);

// File: tb/tb_sreg_burst_master.sv
`timescale 1ns/1ps
module tb_sreg_burst_master;

  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i, write_i, miso_i;
  logic [7:0] addr_i, wdata_i;
  logic [3:0] count_i;
  logic       wreq_o, rvalid_o, done_o, err_o, busy_o, sclk_o, mosi_o, csn_o;
  logic [7:0] rdata_o;

  always #2.5 clk = ~clk;

  sreg_burst_master #(.DIV_HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .write_i(write_i), .count_i(count_i), .wdata_i(wdata_i),
    .wreq_o(wreq_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .done_o(done_o), .err_o(err_o), .busy_o(busy_o), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .csn_o(csn_o)
  );

  // vector: {write, addr, count, seed}
  localparam logic [20:0] VEC [0:5] = '{
    {1'b1, 8'h12, 4'd1, 8'h3C},
    {1'b0, 8'hA7, 4'd1, 8'h00},
    {1'b1, 8'h40, 4'd4, 8'h91},
    {1'b0, 8'hFF, 4'd3, 8'h00},
    {1'b1, 8'h00, 4'd7, 8'h5E},
    {1'b0, 8'h3B, 4'd8, 8'h00}
  };

  int  total = 0, bad = 0;
  bit  finished = 1'b0;
  int  cyc = 0;
  int  rises, csn_falls, done_cnt, err_cnt, wreq_cnt, rvalid_cnt;
  int  bad_half, mosi_bad, rd_mosi_bad, rvalid_bad, done_bad;
  int  last_edge, last_fall, first_gap, hold_gap;
  logic [7:0] cap [0:16];
  logic [7:0] rd  [0:15];
  logic [7:0] cap_sh = 8'h00;
  logic [7:0] cur_addr = 8'h00, cur_seed = 8'h00;
  logic       cur_wr = 1'b0;
  logic       p_sclk = 1'b0, p_csn = 1'b1, p_mosi = 1'b0, p_rvalid = 1'b0;

  function automatic logic [7:0] wbyte(input logic [7:0] s, input int i);
    return (s + 8'(i * 59)) ^ 8'hC6;
  endfunction

  function automatic logic [7:0] rbyte(input logic [7:0] a, input int i);
    return (a ^ 8'h5A) + 8'(i * 53 + 17);
  endfunction

  function automatic logic resp_bit(input int r);
    int k;
    logic [7:0] b;
    k = r / 8;
    b = (k < 2) ? 8'hC3 : rbyte(cur_addr, k - 2);
    return b[7 - (r % 8)];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    rises = 0; csn_falls = 0; done_cnt = 0; err_cnt = 0; wreq_cnt = 0;
    rvalid_cnt = 0; bad_half = 0; mosi_bad = 0; rd_mosi_bad = 0;
    rvalid_bad = 0; done_bad = 0; first_gap = -1; hold_gap = -1;
    for (int i = 0; i < 17; i++) cap[i] = 8'h00;
    for (int i = 0; i < 16; i++) rd[i] = 8'h00;
  endtask

  // Peripheral model and observer, all at the falling system edge
  initial begin
    clear_mon();
    last_edge = 0;
    last_fall = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (p_csn && !csn_o) begin
        csn_falls++;
        last_edge = cyc;
      end
      if (!p_csn && csn_o) hold_gap = cyc - last_fall;
      if (!csn_o && (sclk_o != p_sclk)) begin
        if (cyc - last_edge != HALF) bad_half++;
        if (sclk_o && rises == 0) first_gap = cyc - last_edge;
        last_edge = cyc;
      end
      if (sclk_o && !p_sclk) begin
        cap_sh = {cap_sh[6:0], mosi_o};
        if ((rises % 8 == 7) && (rises / 8 <= 16)) cap[rises / 8] = cap_sh;
        if (!cur_wr && rises >= 16 && mosi_o) rd_mosi_bad++;
        rises++;
      end
      if (!sclk_o && p_sclk) last_fall = cyc;
      if (sclk_o && p_sclk && (mosi_o != p_mosi)) mosi_bad++;
      if (csn_o && sclk_o) mosi_bad++;
      if (rvalid_o) begin
        if (p_rvalid || !(sclk_o && !p_sclk)) rvalid_bad++;
        if (rvalid_cnt < 16) rd[rvalid_cnt] = rdata_o;
        rvalid_cnt++;
      end
      if (done_o) begin
        done_cnt++;
        if (!(csn_o && !p_csn) || busy_o) done_bad++;
      end
      if (err_o) err_cnt++;
      if (wreq_o) begin
        wdata_i = wbyte(cur_seed, wreq_cnt);
        wreq_cnt++;
      end
      miso_i   = resp_bit(rises);
      p_sclk   = sclk_o;
      p_csn    = csn_o;
      p_mosi   = mosi_o;
      p_rvalid = rvalid_o;
    end
  end

  task automatic wait_done(input int lim);
    for (int i = 0; i < lim && done_cnt == 0; i++) @(negedge clk);
  endtask

  task automatic begin_txn(input logic wr, input logic [7:0] a,
                           input logic [3:0] n, input logic [7:0] s);
    @(posedge clk);
    #1;
    clear_mon();
    cur_wr = wr; cur_addr = a; cur_seed = s;
    @(negedge clk);
    start_i = 1'b1; addr_i = a; write_i = wr; count_i = n;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1 && csn_o === 1'b0, "R11 busy/select after start",
        {busy_o, csn_o}, 2'b10);
  endtask

  task automatic check_txn(input logic wr, input logic [7:0] a,
                           input logic [3:0] n, input logic [7:0] s);
    int nn;
    nn = int'(n);
    chk(rises == 8 * (nn + 2), "R6 rising edge count", rises, 8 * (nn + 2));
    chk(csn_falls == 1, "R6 single select", csn_falls, 1);
    chk(cap[0] == a, "R2 address byte", cap[0], a);
    chk(cap[1] == {wr, 3'b000, n}, "R3 control byte", cap[1], {wr, 3'b000, n});
    chk(first_gap == HALF, "R5 select setup", first_gap, HALF);
    chk(hold_gap == HALF, "R5 select hold", hold_gap, HALF);
    chk(bad_half == 0, "R5 half period", bad_half, 0);
    chk(mosi_bad == 0, "R4 data-out timing", mosi_bad, 0);
    chk(done_cnt == 1 && done_bad == 0, "R11 done pulse", done_cnt, 1);
    if (wr) begin
      chk(wreq_cnt == nn, "R7 request count", wreq_cnt, nn);
      for (int i = 0; i < nn; i++)
        chk(cap[i + 2] == wbyte(s, i), "R7 write byte", cap[i + 2], wbyte(s, i));
      chk(rvalid_cnt == 0, "R8 no valid in write", rvalid_cnt, 0);
    end else begin
      chk(rvalid_cnt == nn, "R8 valid count", rvalid_cnt, nn);
      for (int i = 0; i < nn; i++)
        chk(rd[i] == rbyte(a, i), "R8 read byte", rd[i], rbyte(a, i));
      chk(rd_mosi_bad == 0 && rvalid_bad == 0, "R8 read data-out/strobe",
          rd_mosi_bad + rvalid_bad, 0);
      chk(wreq_cnt == 0, "R7 no request in read", wreq_cnt, 0);
    end
  endtask

  task automatic run_txn(input logic wr, input logic [7:0] a,
                         input logic [3:0] n, input logic [7:0] s);
    begin_txn(wr, a, n, s);
    wait_done(4000);
    repeat (4) @(negedge clk);
    check_txn(wr, a, n, s);
  endtask

  initial begin
    start_i = 1'b0; addr_i = 8'h00; write_i = 1'b0; count_i = 4'd0;
    wdata_i = 8'h00; miso_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(csn_o === 1'b1 && sclk_o === 1'b0 && mosi_o === 1'b0, "R1 lines in reset",
        {csn_o, sclk_o, mosi_o}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(csn_o === 1'b1 && sclk_o === 1'b0 && mosi_o === 1'b0, "R1 lines after reset",
        {csn_o, sclk_o, mosi_o}, 3'b100);
    chk({busy_o, done_o, err_o, rvalid_o, wreq_o} === 5'b0, "R1 status after reset",
        {busy_o, done_o, err_o, rvalid_o, wreq_o}, 0);

    for (int v = 0; v < 6; v++)
      run_txn(VEC[v][20], VEC[v][19:12], VEC[v][11:8], VEC[v][7:0]);

    // R12: largest burst both ways
    run_txn(1'b1, 8'hE1, 4'd15, 8'h77);
    run_txn(1'b0, 8'h6C, 4'd15, 8'h00);

    // R9: zero count refused
    @(posedge clk);
    #1;
    clear_mon();
    @(negedge clk);
    start_i = 1'b1; addr_i = 8'h55; write_i = 1'b1; count_i = 4'd0;
    @(negedge clk);
    start_i = 1'b0;
    repeat (50) @(negedge clk);
    chk(err_cnt == 1, "R9 error pulse", err_cnt, 1);
    chk(csn_falls == 0 && rises == 0, "R9 no select", csn_falls + rises, 0);
    chk(done_cnt == 0, "R9 no done", done_cnt, 0);

    // R10: start while busy is ignored
    begin_txn(1'b1, 8'h21, 4'd3, 8'h0F);
    repeat (6) @(negedge clk);
    start_i = 1'b1; addr_i = 8'h99; write_i = 1'b0; count_i = 4'd2;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(4000);
    repeat (200) @(negedge clk);
    chk(rises == 40, "R10 frame length kept", rises, 40);
    chk(cap[0] == 8'h21, "R10 address kept", cap[0], 8'h21);
    chk(cap[1] == 8'h83, "R10 control kept", cap[1], 8'h83);
    chk(csn_falls == 1 && done_cnt == 1, "R10 no second transaction",
        csn_falls + done_cnt, 2);
    chk(err_cnt == 0, "R10 no error", err_cnt, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule